// File: doc/BRIEF.md
# Supply-Fail Deselect and Interrupt Sequencer

This block guards a battery-backed static memory while its main supply falls and rises again. Two digital comparator flags tell it where the supply stands. One says the supply is above the deselect threshold. The other says it is above the lower level where the battery takes over. A one-microsecond tick drives its timers. When the supply sags, it first pulls an open-drain interrupt line low so that the host can finish its work. A bounded delay later it cuts the memory off: select and write are forced inactive and the data pins float.

When the supply falls below the battery level, the block enters battery mode at once and ignores every input. On the way back up it releases the interrupt straight away. It still holds the memory deselected for a recovery interval of about a millisecond before the host's enables are honoured again. The comparator flags are asynchronous, so each one passes through a small synchronizer before the sequencer uses it. The microsecond tick and the memory controls are treated as already synchronous to the clock.

Top module: `pwrfail_guard`

## Requirements
- R1: Synchronous reset puts the block in the recovery state. While reset is held: `mem_sel`=0, `mem_wr`=0, `irq_pull`=0, `bat_mode`=0. With a tick on every cycle, the memory first becomes selectable on the 1000th clock edge (the `RECOVER_US` default) after reset is released.
- R2: In normal operation, `mem_sel` = (`en_lo_n`==0 && `en_hi`==1) and `mem_wr` = `mem_sel` && (`wr_req_n`==0). Also, `irq_pull`=0 and `bat_mode`=0.
- R3: A low level on `vcc_ok` is seen after two synchronizer stages. `irq_pull` goes to 1 (1 means the interrupt line is pulled low) on the third clock edge after the drop. Until the deselect delay ends, `mem_sel` keeps following the enables.
- R4: Deselect takes effect on the `DESEL_DLY_US`-th tick after the interrupt is raised. The default of 25 lies inside the 10 to 40 us window. With a tick on every cycle, `mem_sel` falls on the 28th edge after `vcc_ok` drops.
- R5: While deselected, `mem_sel` and `mem_wr` stay 0 whatever the enable and write inputs do, and `irq_pull` stays 1.
- R6: A low level on `vcc_main` enters battery mode three edges after the drop, from any state. In battery mode, `bat_mode`=1, `irq_pull`=1 and `mem_sel`=`mem_wr`=0. A pending deselect delay is cut short.
- R7: When `vcc_ok` returns (from the pending, deselected or battery states, with `vcc_main` high), the block enters recovery. There, `irq_pull` is released within three edges and the memory stays deselected for `RECOVER_US` ticks.
- R8: A supply dip during recovery, or during the pending delay, never reaches normal directly. A dip in recovery goes to the deselected state (`irq_pull`=1), and the recovery count restarts in full on the next return.
- R9: Leaving battery mode with `vcc_main` high but `vcc_ok` still low gives the deselected state: `bat_mode`=0, `irq_pull`=1, `mem_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Comparator flag: supply above the deselect threshold (asynchronous) |
| vcc_main | input | 1 | Comparator flag: supply above the battery switchover level (asynchronous) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| en_lo_n | input | 1 | Active-low memory enable from the host |
| en_hi | input | 1 | Active-high memory enable from the host |
| wr_req_n | input | 1 | Active-low write strobe from the host |
| mem_sel | output | 1 | Gated select to the memory array; 0 forces write protect and floating data |
| mem_wr | output | 1 | Gated write enable to the memory array |
| irq_pull | output | 1 | 1 drives the open-drain interrupt line low |
| bat_mode | output | 1 | 1 while the memory runs from the battery |

## Verification
A wrong sequencer state shows up at the ports on the same cycle. `mem_sel` and `mem_wr` are derived directly from the state and the host enables. So a premature or missing deselect, or a select leaking through battery or recovery, is visible as soon as the enables are active. An error in the shared timer shows only as a select edge that is one or more ticks early or late. For that reason the delay and recovery boundaries are sampled on the exact edge before and after they should occur. A wrong interrupt or battery state shows within three edges of a supply flag change, because that is the synchronizer latency plus one state register.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    typedef enum logic [2:0] {
        PF_NORMAL  = 3'd0,
        PF_PENDING = 3'd1,
        PF_DESEL   = 3'd2,
        PF_BATTERY = 3'd3,
        PF_RECOVER = 3'd4
    } pf_state_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic irq_pull;
        logic bat;
    } pf_out_s;

    // interrupt line is held low whenever supply is not known good
    function automatic logic pf_irq_active(pf_state_e s);
        return (s == PF_PENDING) || (s == PF_DESEL) || (s == PF_BATTERY);
    endfunction

    // memory access is honoured only in normal operation or before the deselect delay ends
    function automatic logic pf_access_open(pf_state_e s);
        return (s == PF_NORMAL) || (s == PF_PENDING);
    endfunction

    function automatic int pf_max(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pf_seq.sv
module pf_seq
    import pwrfail_pkg::*;
#(
    parameter int DESEL_DLY_US = 25,
    parameter int RECOVER_US   = 1000,
    localparam int CW = $clog2(pf_max(DESEL_DLY_US, RECOVER_US) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ok_s,
    input  logic          main_s,
    input  logic          tick,
    output pf_state_e     state,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] DLY_LAST = CW'(DESEL_DLY_US - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(RECOVER_US - 1);

    pf_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PF_NORMAL: begin
                if (!main_s)    nxt = PF_BATTERY;
                else if (!ok_s) nxt = PF_PENDING;
            end
            PF_PENDING: begin
                if (!main_s)                     nxt = PF_BATTERY;
                else if (ok_s)                   nxt = PF_RECOVER;
                else if (tick && cnt == DLY_LAST) nxt = PF_DESEL;
            end
            PF_DESEL: begin
                if (!main_s)    nxt = PF_BATTERY;
                else if (ok_s)  nxt = PF_RECOVER;
            end
            PF_BATTERY: begin
                if (main_s && ok_s) nxt = PF_RECOVER;
                else if (main_s)    nxt = PF_DESEL;
            end
            PF_RECOVER: begin
                if (!main_s)                      nxt = PF_BATTERY;
                else if (!ok_s)                   nxt = PF_DESEL;
                else if (tick && cnt == REC_LAST) nxt = PF_NORMAL;
            end
            default: nxt = PF_RECOVER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PF_RECOVER;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= '0;
            end else if (tick && (state == PF_PENDING || state == PF_RECOVER)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pf_gate.sv
module pf_gate
    import pwrfail_pkg::*;
(
    input  pf_state_e state,
    input  logic      en_lo_n,
    input  logic      en_hi,
    input  logic      wr_req_n,
    output pf_out_s   o
);
    logic decode;

    always_comb begin
        decode     = !en_lo_n && en_hi;
        o.sel      = decode && pf_access_open(state);
        o.wr       = o.sel && !wr_req_n;
        o.irq_pull = pf_irq_active(state);
        o.bat      = (state == PF_BATTERY);
    end
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
    import pwrfail_pkg::*;
#(
    parameter int DESEL_DLY_US = 25,
    parameter int RECOVER_US   = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_ok,
    input  logic vcc_main,
    input  logic us_tick,
    input  logic en_lo_n,
    input  logic en_hi,
    input  logic wr_req_n,
    output logic mem_sel,
    output logic mem_wr,
    output logic irq_pull,
    output logic bat_mode
);
    localparam int CW = $clog2(pf_max(DESEL_DLY_US, RECOVER_US) + 1);

    logic          ok_s;
    logic          main_s;
    pf_state_e     state;
    logic [CW-1:0] cnt;
    pf_out_s       outs;

    pf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ok (
        .clk(clk), .rst(rst), .d(vcc_ok), .q(ok_s)
    );

    pf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_main (
        .clk(clk), .rst(rst), .d(vcc_main), .q(main_s)
    );

    pf_seq #(.DESEL_DLY_US(DESEL_DLY_US), .RECOVER_US(RECOVER_US)) u_seq (
        .clk(clk), .rst(rst), .ok_s(ok_s), .main_s(main_s),
        .tick(us_tick), .state(state), .cnt(cnt)
    );

    pf_gate u_gate (
        .state(state), .en_lo_n(en_lo_n), .en_hi(en_hi),
        .wr_req_n(wr_req_n), .o(outs)
    );

    assign mem_sel  = outs.sel;
    assign mem_wr   = outs.wr;
    assign irq_pull = outs.irq_pull;
    assign bat_mode = outs.bat;
endmodule

// File: rtl/pwrfail_guard_chk.sv
module pwrfail_guard_chk
    import pwrfail_pkg::*;
#(
    parameter int DESEL_DLY_US = 25,
    parameter int RECOVER_US   = 1000,
    parameter int CW           = 10
) (
    input logic          clk,
    input logic          rst,
    input pf_state_e     state,
    input logic [CW-1:0] cnt,
    input logic          en_lo_n,
    input logic          en_hi,
    input logic          wr_req_n,
    input logic          mem_sel,
    input logic          mem_wr,
    input logic          irq_pull,
    input logic          bat_mode
);
    p_sel_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> (!en_lo_n && en_hi));

    p_wr_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_sel && !wr_req_n));

    p_delay_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == PF_PENDING) |-> (int'(cnt) < DESEL_DLY_US));

    p_desel_after_delay_r4: assert property (@(posedge clk) disable iff (rst)
        (state == PF_DESEL && $past(state) == PF_PENDING) |->
            (int'($past(cnt)) == DESEL_DLY_US - 1));

    p_desel_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (state == PF_DESEL) |-> (!mem_sel && !mem_wr && irq_pull));

    p_battery_isolated_r6: assert property (@(posedge clk) disable iff (rst)
        bat_mode |-> (!mem_sel && !mem_wr && irq_pull));

    p_recover_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PF_RECOVER) |-> (!irq_pull && !mem_sel && int'(cnt) < RECOVER_US));

    p_normal_via_recover_r8: assert property (@(posedge clk) disable iff (rst)
        (state == PF_NORMAL && $past(state) != PF_NORMAL) |->
            ($past(state) == PF_RECOVER && int'($past(cnt)) == RECOVER_US - 1));
endmodule

bind pwrfail_guard pwrfail_guard_chk #(
    .DESEL_DLY_US(DESEL_DLY_US), .RECOVER_US(RECOVER_US), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .state(state), .cnt(cnt),
    .en_lo_n(en_lo_n), .en_hi(en_hi), .wr_req_n(wr_req_n),
    .mem_sel(mem_sel), .mem_wr(mem_wr), .irq_pull(irq_pull), .bat_mode(bat_mode)
);

// File: tb/pwrfail_guard_test.sv
`timescale 1ns/1ps
module pwrfail_guard_test;
    localparam int DLY = 25;
    localparam int REC = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok = 1'b1, vcc_main = 1'b1, us_tick = 1'b1;
    logic en_lo_n = 1'b0, en_hi = 1'b1, wr_req_n = 1'b0;
    logic mem_sel, mem_wr, irq_pull, bat_mode;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwrfail_guard uut (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vcc_main(vcc_main),
        .us_tick(us_tick), .en_lo_n(en_lo_n), .en_hi(en_hi), .wr_req_n(wr_req_n),
        .mem_sel(mem_sel), .mem_wr(mem_wr), .irq_pull(irq_pull), .bat_mode(bat_mode)
    );

    // ---- bench reference model built from the requirements ----
    localparam int M_NORM = 0, M_PEND = 1, M_DESEL = 2, M_BAT = 3, M_REC = 4;
    int m_st = M_REC;
    int m_cnt = 0;
    logic m_o1 = 1, m_o2 = 1, m_b1 = 1, m_b2 = 1;

    always @(posedge clk) begin
        int nx;
        if (rst) begin
            m_st <= M_REC; m_cnt <= 0;
            m_o1 <= 1; m_o2 <= 1; m_b1 <= 1; m_b2 <= 1;
        end else begin
            nx = m_st;
            case (m_st)
                M_NORM:  if (!m_b2) nx = M_BAT; else if (!m_o2) nx = M_PEND;
                M_PEND:  if (!m_b2) nx = M_BAT; else if (m_o2) nx = M_REC;
                         else if (us_tick && m_cnt == DLY-1) nx = M_DESEL;
                M_DESEL: if (!m_b2) nx = M_BAT; else if (m_o2) nx = M_REC;
                M_BAT:   if (m_b2 && m_o2) nx = M_REC; else if (m_b2) nx = M_DESEL;
                default: if (!m_b2) nx = M_BAT; else if (!m_o2) nx = M_DESEL;
                         else if (us_tick && m_cnt == REC-1) nx = M_NORM;
            endcase
            if (nx != m_st) m_cnt <= 0;
            else if (us_tick && (m_st == M_PEND || m_st == M_REC)) m_cnt <= m_cnt + 1;
            m_st <= nx;
            m_o1 <= vcc_ok; m_o2 <= m_o1; m_b1 <= vcc_main; m_b2 <= m_b1;
        end
    end

    function automatic logic [3:0] expect_out(int st, logic lo_n, logic hi, logic wn);
        logic sel;
        sel = !lo_n && hi && (st == M_NORM || st == M_PEND);
        return {sel, sel && !wn, (st == M_PEND || st == M_DESEL || st == M_BAT), st == M_BAT};
    endfunction

    function automatic string tag_of(int st);
        case (st)
            M_NORM:  return "R2";
            M_PEND:  return "R3";
            M_DESEL: return "R5";
            M_BAT:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // per-cycle comparison 1 ns after each edge
    always @(posedge clk) begin
        logic [3:0] e, a;
        #1;
        if (!done) begin
            e = expect_out(m_st, en_lo_n, en_hi, wr_req_n);
            a = {mem_sel, mem_wr, irq_pull, bat_mode};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s {sel,wr,irq,bat} actual=%b expected=%b t=%0t",
                         rst ? "R1" : tag_of(m_st), a, e, $time);
            end
        end
    end

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {sel,wr,irq,bat} actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] outs();
        return {mem_sel, mem_wr, irq_pull, bat_mode};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        chk("R1 reset state", outs(), 4'b0000);
        rst = 1'b0;
        // R1: recovery after reset, tick every cycle
        step(REC - 1);
        chk("R1 still recovering", outs(), 4'b0000);
        step(1);
        chk("R1 selectable", outs(), 4'b1100);
        wr_req_n = 1'b1; #1;
        chk("R2 read only", outs(), 4'b1000);
        wr_req_n = 1'b0;
        // R3 / R4: supply sag timing
        @(negedge clk); vcc_ok = 1'b0;
        step(2);
        chk("R3 not yet", outs(), 4'b1100);
        step(1);
        chk("R3 irq raised, access open", outs(), 4'b1110);
        step(DLY - 1);
        chk("R4 last cycle before deselect", outs(), 4'b1110);
        step(1);
        chk("R4 deselected", outs(), 4'b0010);
        en_lo_n = 1'b0; en_hi = 1'b1; wr_req_n = 1'b0; #1;
        chk("R5 controls ignored", outs(), 4'b0010);
        // R7: return to recovery
        vcc_ok = 1'b1;
        step(3);
        chk("R7 irq released", outs(), 4'b0000);
        // R8: dip during recovery
        vcc_ok = 1'b0;
        step(3);
        chk("R8 dip deselects", outs(), 4'b0010);
        vcc_ok = 1'b1;
        step(3);
        step(REC - 1);
        chk("R8 recovery restarted in full", outs(), 4'b0000);
        step(1);
        chk("R7 normal after recovery", outs(), 4'b1100);
        // R6: fast fall cuts pending delay
        vcc_ok = 1'b0;
        step(3);
        chk("R3 pending", outs(), 4'b1110);
        vcc_main = 1'b0;
        step(3);
        chk("R6 battery skips delay", outs(), 4'b0011);
        // R9: leave battery with only the main flag
        vcc_main = 1'b1;
        step(3);
        chk("R9 battery to deselect", outs(), 4'b0010);
        vcc_ok = 1'b1;
        step(3);
        chk("R7 recovery from deselect", outs(), 4'b0000);
        step(REC);
        chk("R7 normal again", outs(), 4'b1100);

        // constrained random phase, checked by the per-cycle model comparison
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            en_lo_n  = ($urandom % 4) == 0;
            en_hi    = ($urandom % 4) != 0;
            wr_req_n = $urandom % 2;
            us_tick  = ($urandom % 3) != 0;
            if ($urandom % 2500 == 0) vcc_ok   = ~vcc_ok;
            if ($urandom % 7000 == 0) vcc_main = ~vcc_main;
        end
        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule